// File: doc/BRIEF.md
# Cheat Cartridge Patch Register Unit

This block sits between a 68000-style processor bus and a cartridge ROM and lets a small boot program plant up to six word-sized patches in the ROM image. Before the patches are armed, the low 64 KB of the address space is served by an internal 32 KB boot ROM, mirrored once. Writes to that same low region land in a file of 32 word registers. The boot program fills the registers with address/data pairs, then writes the mode register with the lock bit set. From then on the registers are frozen, and every cartridge read is compared with the six patch slots during that read.

A mode bit chooses whether reads of the low region come from the boot ROM or from the cartridge. A second mode bit lets the boot program read its registers back while the boot ROM is selected. Both ROMs sit outside the block. The block drives a word address to each ROM and takes the returned data combinationally in the same cycle. Each request is answered one cycle later with a ready pulse and registered read data.

Top module: `cheat_patch_unit`

## Requirements
- R1: Every cycle with `bus_valid` high is followed in the next cycle by `bus_ready` high. `bus_ready` is low in the cycle after a cycle without a request. For reads, `bus_rdata` holds the answer during that ready cycle.
- R2: A write whose address has bits [23:16] all zero goes to register `bus_addr[5:1]`, so higher address bits alias. `bus_be[1]` writes bits 15:8 and `bus_be[0]` writes bits 7:0. A byte left unstrobed keeps its old value.
- R3: Register 0 is the mode register. When its bit 10 is set, reads of the low region (bits [23:16] zero) come from the cartridge ROM at the same word address. When bit 10 is clear, they come from the boot ROM.
- R4: The boot ROM word address is `bus_addr[14:1]`, so the 32 KB image repeats at byte offset 0x8000.
- R5: With mode bit 10 clear and mode bit 9 set, a low-region read returns register `bus_addr[5:1]`. With bit 9 clear, it returns boot ROM data, and the registers cannot be read.
- R6: Any write to register 1 leaves that register's bit 0 at one, whatever the write data.
- R7: Once mode bit 8 (lock) is set, every register write is ignored. This includes writes to the mode register.
- R8: Slot i (i = 0..5) has the 22-bit word address {reg[3i+2][5:0], reg[3i+3]} and the data reg[3i+4]. While locked, a cartridge read with `bus_addr[23]` zero and `bus_addr[22:1]` equal to the slot address returns the slot data in place of the ROM word.
- R9: A slot whose data register is zero never matches.
- R10: When several slots match, the lowest-numbered slot supplies the data.
- R11: Before lock, cartridge reads return raw ROM data, even when the slot registers are filled.
- R12: Reset clears all registers and selects the boot ROM. It drops `bus_ready` and sets `bus_rdata` to zero. This also removes all patches.
- R13: A write outside the low region changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 23 | Word address, byte address bits 23:1 |
| bus_be | input | 2 | Byte strobes: bit 1 = bits 15:8, bit 0 = bits 7:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_ready | output | 1 | Access completion, one cycle after the request |
| boot_rom_addr | output | 14 | Boot ROM word address |
| boot_rom_data | input | 16 | Boot ROM word, combinational return |
| cart_rom_addr | output | 23 | Cartridge ROM word address |
| cart_rom_data | input | 16 | Cartridge ROM word, combinational return |

## Verification
Two functions meet in one access: the steering of low-region reads by mode bit 10, and the live patch comparison. The bench places slot 2 at word address 3, inside the low region, then locks with the cartridge selected. A single read of byte address 0x000006 must then return the patch word rather than either ROM. A second collision comes from two slots holding the same address. There the lowest index must win, and an empty slot must yield to a later one. The expected words are computed from the slot layout in the requirements, and the bench ROM models are simple address functions.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  // mode register bit positions (register 0)
  localparam int unsigned LOCK_BIT = 8;
  localparam int unsigned RDEN_BIT = 9;
  localparam int unsigned CART_BIT = 10;
  // width of the high slot address field taken from the first slot register
  localparam int unsigned SLOT_HI_W = 6;

  typedef enum logic [1:0] {
    SRC_BOOT = 2'd0,
    SRC_REGS = 2'd1,
    SRC_CART = 2'd2
  } rd_src_e;
endpackage

// File: rtl/cpr_regfile.sv
module cpr_regfile #(
  parameter int DATA_W = 16,
  parameter int REG_AW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   wr_idx,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   regs_q [1<<REG_AW],
  output logic                locked
);
  import cpr_pkg::*;

  localparam int NREG = 1 << REG_AW;
  localparam int BE_W = DATA_W / 8;

  logic [DATA_W-1:0] regs_d [NREG];
  logic              wr_ok;

  assign locked = regs_q[0][LOCK_BIT];

  // next-state: byte merge into the indexed register, register 1 bit 0 forced
  always_comb begin
    regs_d = regs_q;
    wr_ok  = wr_en && !locked;
    if (wr_ok) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be[b]) regs_d[wr_idx][b*8 +: 8] = wr_data[b*8 +: 8];
      end
      if (wr_idx == REG_AW'(1)) regs_d[1][0] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_ok) begin
      regs_q <= regs_d;
    end
  end

  // R7: once locked the mode register never changes and stays locked
  p_lock_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(regs_q[0]) && locked));

  // R6: an accepted write to register 1 leaves bit 0 set
  p_reg1_bit0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !locked && wr_idx == REG_AW'(1)) |=> regs_q[1][0]);
endmodule

// File: rtl/cpr_bus_decode.sv
module cpr_bus_decode #(
  parameter int ADDR_W  = 24,
  parameter int REG_AW  = 5,
  parameter int BOOT_AW = 14,
  parameter int LOW_AW  = 16,
  parameter int PADDR_W = 22
) (
  input  logic [ADDR_W-1:1]  bus_addr,
  input  logic               cart_sel,
  input  logic               rden,
  output logic               low_hit,
  output logic [REG_AW-1:0]  reg_idx,
  output logic [BOOT_AW-1:0] boot_waddr,
  output logic [ADDR_W-2:0]  cart_waddr,
  output logic [PADDR_W-1:0] patch_waddr,
  output logic               patch_ok,
  output cpr_pkg::rd_src_e   rd_src
);
  import cpr_pkg::*;

  assign low_hit     = (bus_addr[ADDR_W-1:LOW_AW] == '0);
  assign reg_idx     = bus_addr[REG_AW:1];
  assign boot_waddr  = bus_addr[BOOT_AW:1];
  assign cart_waddr  = bus_addr[ADDR_W-1:1];
  assign patch_waddr = bus_addr[PADDR_W:1];
  assign patch_ok    = (bus_addr[ADDR_W-1:PADDR_W+1] == '0);

  always_comb begin
    if (!low_hit || cart_sel) rd_src = SRC_CART;
    else if (rden)            rd_src = SRC_REGS;
    else                      rd_src = SRC_BOOT;
  end
endmodule

// File: rtl/cpr_patch_match.sv
module cpr_patch_match #(
  parameter int NUM_SLOTS = 6,
  parameter int DATA_W    = 16,
  parameter int PADDR_W   = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               addr_ok,
  input  logic [PADDR_W-1:0] rd_waddr,
  input  logic [PADDR_W-1:0] slot_addr [NUM_SLOTS],
  input  logic [DATA_W-1:0]  slot_data [NUM_SLOTS],
  output logic               hit,
  output logic [DATA_W-1:0]  hit_data
);
  logic [NUM_SLOTS-1:0] slot_hit;

  // one comparator per slot, all in parallel
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    assign slot_hit[i] = enable && addr_ok && (slot_data[i] != '0) &&
                         (slot_addr[i] == rd_waddr);
  end

  // walk downward so the lowest index is written last and wins
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slot_hit[i]) begin
        hit      = 1'b1;
        hit_data = slot_data[i];
      end
    end
  end

  // R11: no substitution before lock
  p_unlocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !hit);

  // R9: a hit never delivers an empty slot
  p_hit_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hit_data != '0));
endmodule

// File: rtl/cheat_patch_unit.sv
module cheat_patch_unit #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int REG_AW    = 5,
  parameter int NUM_SLOTS = 6,
  parameter int BOOT_AW   = 14,
  parameter int LOW_AW    = 16,
  parameter int PADDR_W   = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_we,
  input  logic [ADDR_W-1:1]  bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_ready,
  output logic [BOOT_AW-1:0] boot_rom_addr,
  input  logic [DATA_W-1:0]  boot_rom_data,
  output logic [ADDR_W-2:0]  cart_rom_addr,
  input  logic [DATA_W-1:0]  cart_rom_data
);
  import cpr_pkg::*;

  localparam int NREG   = 1 << REG_AW;
  localparam int LO_W   = PADDR_W - SLOT_HI_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  logic [DATA_W-1:0]  regs_q [NREG];
  logic               locked;
  logic               low_hit;
  logic [REG_AW-1:0]  reg_idx;
  logic [PADDR_W-1:0] patch_waddr;
  logic               patch_ok;
  rd_src_e            rd_src;
  logic [PADDR_W-1:0] slot_addr [NUM_SLOTS];
  logic [DATA_W-1:0]  slot_data [NUM_SLOTS];
  logic               hit;
  logic [DATA_W-1:0]  hit_data;
  logic               wr_req;
  logic               rd_fire;
  logic [DATA_W-1:0]  rdata_d;
  logic [DATA_W-1:0]  rdata_q;
  logic               ready_q;

  assign wr_req  = bus_valid && bus_we && low_hit;
  assign rd_fire = bus_valid && !bus_we;

  cpr_regfile #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_req),
    .wr_idx  (reg_idx),
    .wr_be   (bus_be),
    .wr_data (bus_wdata),
    .regs_q  (regs_q),
    .locked  (locked)
  );

  cpr_bus_decode #(
    .ADDR_W(ADDR_W), .REG_AW(REG_AW), .BOOT_AW(BOOT_AW),
    .LOW_AW(LOW_AW), .PADDR_W(PADDR_W)
  ) u_dec (
    .bus_addr    (bus_addr),
    .cart_sel    (regs_q[0][CART_BIT]),
    .rden        (regs_q[0][RDEN_BIT]),
    .low_hit     (low_hit),
    .reg_idx     (reg_idx),
    .boot_waddr  (boot_rom_addr),
    .cart_waddr  (cart_rom_addr),
    .patch_waddr (patch_waddr),
    .patch_ok    (patch_ok),
    .rd_src      (rd_src)
  );

  // slot i: high address bits, low address bits, data in three consecutive registers
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slot_addr[i] = {regs_q[3*i+2][SLOT_HI_W-1:0], regs_q[3*i+3][LO_W-1:0]};
    assign slot_data[i] = regs_q[3*i+4];
  end

  cpr_patch_match #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .PADDR_W(PADDR_W)
  ) u_match (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .enable    (locked),
    .addr_ok   (patch_ok),
    .rd_waddr  (patch_waddr),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .hit       (hit),
    .hit_data  (hit_data)
  );

  always_comb begin
    case (rd_src)
      SRC_CART: rdata_d = hit ? hit_data : cart_rom_data;
      SRC_REGS: rdata_d = regs_q[reg_idx];
      default:  rdata_d = boot_rom_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= bus_valid;
      if (rd_fire) rdata_q <= rdata_d;
    end
  end

  assign bus_ready = ready_q;
  assign bus_rdata = rdata_q;

  // R1: a request is answered in the following cycle
  p_ready_follows_r1: assert property (@(posedge clk) disable iff (!rst_n_int)
    bus_valid |=> bus_ready);

  // R1: no ready without a request
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n_int)
    !bus_valid |=> !bus_ready);

  // R8: a patched cartridge read returns the slot word
  p_patch_word_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_fire && rd_src == SRC_CART && hit) |=> (bus_rdata == $past(hit_data)));

  // R5: boot-sourced reads return the boot ROM word
  p_boot_word_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_fire && rd_src == SRC_BOOT) |=> (bus_rdata == $past(boot_rom_data)));
endmodule

// File: tb/tb_cheat_patch_unit.sv
module tb_cheat_patch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam logic [1:0] K_LIT  = 2'd0;
  localparam logic [1:0] K_CART = 2'd1;
  localparam logic [1:0] K_BOOT = 2'd2;

  typedef struct packed {
    logic        rd;
    logic [23:0] a;
    logic [1:0]  be;
    logic [15:0] wd;
    logic [1:0]  kind;
    logic [15:0] ex;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 49;
  localparam vec_t VT [NV] = '{
    '{1'b0, 24'h000000, 2'b11, 16'h0200, K_LIT,  16'h0000, 4'd5},  // R5 readback on
    '{1'b0, 24'h000004, 2'b11, 16'h1234, K_LIT,  16'h0000, 4'd2},  // R2 word write reg2
    '{1'b1, 24'h000004, 2'b11, 16'h0000, K_LIT,  16'h1234, 4'd2},
    '{1'b0, 24'h000004, 2'b01, 16'h00AB, K_LIT,  16'h0000, 4'd2},  // R2 low byte
    '{1'b1, 24'h000004, 2'b11, 16'h0000, K_LIT,  16'h12AB, 4'd2},
    '{1'b0, 24'h000004, 2'b10, 16'hCD00, K_LIT,  16'h0000, 4'd2},  // R2 high byte
    '{1'b1, 24'h000004, 2'b11, 16'h0000, K_LIT,  16'hCDAB, 4'd2},
    '{1'b0, 24'h000002, 2'b11, 16'h0000, K_LIT,  16'h0000, 4'd6},  // R6 reg1 bit0
    '{1'b1, 24'h000002, 2'b11, 16'h0000, K_LIT,  16'h0001, 4'd6},
    '{1'b0, 24'h000042, 2'b11, 16'h5550, K_LIT,  16'h0000, 4'd2},  // R2 alias to reg1
    '{1'b1, 24'h000002, 2'b11, 16'h0000, K_LIT,  16'h5551, 4'd2},
    '{1'b0, 24'h010004, 2'b11, 16'hFFFF, K_LIT,  16'h0000, 4'd13}, // R13 outside window
    '{1'b1, 24'h000004, 2'b11, 16'h0000, K_LIT,  16'hCDAB, 4'd13},
    '{1'b0, 24'h000000, 2'b11, 16'h0000, K_LIT,  16'h0000, 4'd5},  // R5 readback off
    '{1'b1, 24'h000004, 2'b11, 16'h0000, K_BOOT, 16'h0000, 4'd5},
    '{1'b1, 24'h008004, 2'b11, 16'h0000, K_BOOT, 16'h0000, 4'd4},  // R4 mirror
    '{1'b0, 24'h000000, 2'b11, 16'h0400, K_LIT,  16'h0000, 4'd3},  // R3 cart select
    '{1'b1, 24'h000004, 2'b11, 16'h0000, K_CART, 16'h0000, 4'd3},
    '{1'b0, 24'h000004, 2'b11, 16'h0001, K_LIT,  16'h0000, 4'd8},  // slot0 hi
    '{1'b0, 24'h000006, 2'b11, 16'h0008, K_LIT,  16'h0000, 4'd8},  // slot0 lo
    '{1'b0, 24'h000008, 2'b11, 16'h1111, K_LIT,  16'h0000, 4'd8},  // slot0 data
    '{1'b0, 24'h00000A, 2'b11, 16'h0001, K_LIT,  16'h0000, 4'd10}, // slot1 same address
    '{1'b0, 24'h00000C, 2'b11, 16'h0008, K_LIT,  16'h0000, 4'd10},
    '{1'b0, 24'h00000E, 2'b11, 16'h2222, K_LIT,  16'h0000, 4'd10},
    '{1'b0, 24'h000010, 2'b11, 16'h0000, K_LIT,  16'h0000, 4'd8},  // slot2 word 3
    '{1'b0, 24'h000012, 2'b11, 16'h0003, K_LIT,  16'h0000, 4'd8},
    '{1'b0, 24'h000014, 2'b11, 16'h3333, K_LIT,  16'h0000, 4'd8},
    '{1'b0, 24'h000016, 2'b11, 16'h0002, K_LIT,  16'h0000, 4'd9},  // slot3 empty
    '{1'b0, 24'h000018, 2'b11, 16'h0100, K_LIT,  16'h0000, 4'd9},
    '{1'b0, 24'h00001A, 2'b11, 16'h0000, K_LIT,  16'h0000, 4'd9},
    '{1'b0, 24'h00001C, 2'b11, 16'h0002, K_LIT,  16'h0000, 4'd9},  // slot4 same address
    '{1'b0, 24'h00001E, 2'b11, 16'h0100, K_LIT,  16'h0000, 4'd9},
    '{1'b0, 24'h000020, 2'b11, 16'h4444, K_LIT,  16'h0000, 4'd9},
    '{1'b0, 24'h000022, 2'b11, 16'hFFC5, K_LIT,  16'h0000, 4'd8},  // slot5 hi masked
    '{1'b0, 24'h000024, 2'b11, 16'h7777, K_LIT,  16'h0000, 4'd8},
    '{1'b0, 24'h000026, 2'b11, 16'h5555, K_LIT,  16'h0000, 4'd8},
    '{1'b1, 24'h020010, 2'b11, 16'h0000, K_CART, 16'h0000, 4'd11}, // R11 raw before lock
    '{1'b1, 24'h000006, 2'b11, 16'h0000, K_CART, 16'h0000, 4'd11},
    '{1'b0, 24'h000000, 2'b11, 16'h0500, K_LIT,  16'h0000, 4'd7},  // R7 lock, cart kept
    '{1'b1, 24'h020010, 2'b11, 16'h0000, K_LIT,  16'h1111, 4'd10}, // R10 slot0 over slot1
    '{1'b1, 24'h000006, 2'b11, 16'h0000, K_LIT,  16'h3333, 4'd8},  // R8 low region + patch
    '{1'b1, 24'h040200, 2'b11, 16'h0000, K_LIT,  16'h4444, 4'd9},  // R9 empty slot skipped
    '{1'b1, 24'h0AEEEE, 2'b11, 16'h0000, K_LIT,  16'h5555, 4'd8},  // R8 field mask
    '{1'b1, 24'h020012, 2'b11, 16'h0000, K_CART, 16'h0000, 4'd8},  // R8 neighbour word
    '{1'b0, 24'h000000, 2'b11, 16'h0000, K_LIT,  16'h0000, 4'd7},  // R7 ignored
    '{1'b1, 24'h000006, 2'b11, 16'h0000, K_LIT,  16'h3333, 4'd7},
    '{1'b0, 24'h000008, 2'b11, 16'h9999, K_LIT,  16'h0000, 4'd7},  // R7 ignored
    '{1'b1, 24'h020010, 2'b11, 16'h0000, K_LIT,  16'h1111, 4'd7},
    '{1'b1, 24'h820010, 2'b11, 16'h0000, K_CART, 16'h0000, 4'd8}   // R8 bit 23 set
  };

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_we;
  logic [23:1] bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_ready;
  logic [13:0] boot_rom_addr;
  logic [15:0] boot_rom_data;
  logic [22:0] cart_rom_addr;
  logic [15:0] cart_rom_data;

  int checks;
  int errors;

  function automatic logic [15:0] cart_word(input logic [22:0] w);
    return w[15:0] ^ 16'hA5A5 ^ {9'b0, w[22:16]};
  endfunction

  function automatic logic [15:0] boot_word(input logic [13:0] w);
    return 16'hB000 ^ {2'b0, w};
  endfunction

  assign cart_rom_data = cart_word(cart_rom_addr);
  assign boot_rom_data = boot_word(boot_rom_addr);

  cheat_patch_unit dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_valid     (bus_valid),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_be        (bus_be),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_ready     (bus_ready),
    .boot_rom_addr (boot_rom_addr),
    .boot_rom_data (boot_rom_data),
    .cart_rom_addr (cart_rom_addr),
    .cart_rom_data (cart_rom_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  // one access: drive at a falling edge, sample at the next falling edge
  task automatic access(input vec_t v);
    logic [15:0] exp;
    @(negedge clk);
    bus_valid = 1'b1;
    bus_we    = !v.rd;
    bus_addr  = v.a[23:1];
    bus_be    = v.be;
    bus_wdata = v.wd;
    @(negedge clk);
    bus_valid = 1'b0;
    check(1, {15'b0, bus_ready}, 16'h0001);  // R1 ready after request
    if (v.rd) begin
      case (v.kind)
        K_CART:  exp = cart_word(v.a[23:1]);
        K_BOOT:  exp = boot_word(v.a[14:1]);
        default: exp = v.ex;
      endcase
      check(int'(v.req), bus_rdata, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks    = 0;
    errors    = 0;
    bus_valid = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_be    = 2'b11;
    bus_wdata = '0;
    do_reset();

    // R12: reset state of the bus outputs
    check(12, {15'b0, bus_ready}, 16'h0000);
    check(12, bus_rdata, 16'h0000);
    // R12: boot ROM selected, registers unreadable after reset
    access('{1'b1, 24'h000004, 2'b11, 16'h0, K_BOOT, 16'h0, 4'd12});
    // R1: no ready in an idle cycle
    @(negedge clk);
    check(1, {15'b0, bus_ready}, 16'h0000);

    for (int i = 0; i < NV; i++) access(VT[i]);

    // R12: reset mid-run drops lock, patches and cartridge selection
    do_reset();
    access('{1'b1, 24'h020010, 2'b11, 16'h0, K_CART, 16'h0, 4'd12});
    access('{1'b1, 24'h000006, 2'b11, 16'h0, K_BOOT, 16'h0, 4'd12});
    // R12: registers accept writes again after reset
    access('{1'b0, 24'h000000, 2'b11, 16'h0200, K_LIT, 16'h0, 4'd12});
    access('{1'b1, 24'h000008, 2'b11, 16'h0, K_LIT, 16'h0000, 4'd12});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule